// File: doc/BRIEF.md
# Priority-Banked Working Register File

This block holds the sixteen 32-bit working registers of a processor core. The lower eight registers are banked. The base bank serves priority level 0, and each of the priority levels 1 through 7 has its own private copy of those eight registers. The upper eight registers exist once and every level sees the same copy.

An interrupt at a new level therefore works in a fresh set of low registers without spending any cycles on save or restore. When execution returns to a lower level, the values that level left behind are still there.

The core supplies the active priority level every cycle. The block captures it on the clock edge, so a change of level applies from the next cycle onward. Two combinational read ports and one synchronous write port serve the pipeline. A write forwards its data to any read of the same register in the same cycle.

Top module: `shadow_regfile`

## Requirements
- R1: Synchronous active-low reset clears every word of every bank to zero and makes level 0 the active level. After reset, every register reads 0 at every level.
- R2: The two read ports are combinational and independent of each other. When both ports address the same register in the same cycle, they return the same value.
- R3: Registers 8 through 15 exist in one copy. A value written to one of them at any level reads back unchanged at every other level.
- R4: Level 0 selects the base bank for registers 0 through 7, and levels 1 through 7 each select their own bank. A write to registers 0 through 7 changes only the bank of the active level.
- R5: The `level` input is captured on the clock edge. In the cycle in which `level` changes, reads and the write still use the previously captured level. The new level applies from the next cycle.
- R6: When `wr_en` is 1 and `wr_addr` equals a read address, that read port returns `wr_data` in the same cycle (write-through forwarding).
- R7: A write takes effect at the rising clock edge only when `wr_en` is 1. With `wr_en` at 0, no register changes, whatever `wr_addr` and `wr_data` hold.
- R8: The contents of a bank persist while other levels are active. Returning to a level reads back exactly what that level last wrote.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| level | input | 3 | Active priority level, captured on the clock edge |
| rd0_addr | input | 4 | Register index for read port 0 |
| rd0_data | output | 32 | Read port 0 data, combinational |
| rd1_addr | input | 4 | Register index for read port 1 |
| rd1_data | output | 32 | Read port 1 data, combinational |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 4 | Register index for the write |
| wr_data | input | 32 | Write data |

## Verification
The assertions check four behaviours on every cycle:
- forwarding of a same-cycle write to each read port;
- agreement of the two ports when they read the same register;
- zero reads straight after reset;
- persistence of a write to a shared register, however the level moves.

Bank isolation, the one-cycle lag of a level change and the restoring of a bank after a return to its level depend on long histories. Only the bench's scenarios show these. The bench fills all eight banks with distinct patterns, sweeps every register at every level, and times a level change against a write within a single cycle.

// File: rtl/shadow_rf_pkg.sv
// Package: shared sizing constants for the priority-banked register file.
// Assumes the banked registers form the low half of the register index space.
package shadow_rf_pkg;
    localparam int RF_DATA_W     = 32;
    localparam int RF_NUM_REGS   = 16;
    localparam int RF_NUM_BANKED = 8;
    localparam int RF_NUM_LEVELS = 8;   // base bank plus seven alternates
    localparam int RF_NUM_RD     = 2;
endpackage

// File: rtl/shadow_bank_store.sv
// Module: holds one copy of the banked low registers for every priority level.
// It writes only the copy selected by lvl and presents that copy on view.
// Assumes lvl is already registered by the caller.
module shadow_bank_store #(
    parameter int DATA_W     = 32,
    parameter int NUM_BANKED = 8,
    parameter int NUM_LEVELS = 8,
    localparam int LVL_W     = $clog2(NUM_LEVELS),
    localparam int IDX_W     = $clog2(NUM_BANKED)
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic [LVL_W-1:0]                   lvl,
    input  logic                               we,
    input  logic [IDX_W-1:0]                   waddr,
    input  logic [DATA_W-1:0]                  wdata,
    output logic [NUM_BANKED-1:0][DATA_W-1:0]  view
);
    logic [NUM_BANKED-1:0][DATA_W-1:0] bank_view [NUM_LEVELS];

    for (genvar g = 0; g < NUM_LEVELS; g++) begin : g_bank
        logic [NUM_BANKED-1:0][DATA_W-1:0] words_q;

        // Purpose: store writes aimed at this level's bank.
        always_ff @(posedge clk) begin
            if (!rst_n)
                words_q <= '0;
            else if (we && (lvl == LVL_W'(g)))
                words_q[waddr] <= wdata;
        end

        assign bank_view[g] = words_q;
    end

    // Purpose: present the bank of the active level.
    always_comb view = bank_view[lvl];
endmodule

// File: rtl/shared_reg_store.sv
// Module: the single copy of the upper registers that all levels see.
// Assumes waddr is already rebased to this store's own index range.
module shared_reg_store #(
    parameter int DATA_W     = 32,
    parameter int NUM_SHARED = 8,
    localparam int IDX_W     = $clog2(NUM_SHARED)
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               we,
    input  logic [IDX_W-1:0]                   waddr,
    input  logic [DATA_W-1:0]                  wdata,
    output logic [NUM_SHARED-1:0][DATA_W-1:0]  view
);
    logic [NUM_SHARED-1:0][DATA_W-1:0] words_q;

    // Purpose: store writes to the shared registers.
    always_ff @(posedge clk) begin
        if (!rst_n)
            words_q <= '0;
        else if (we)
            words_q[waddr] <= wdata;
    end

    assign view = words_q;
endmodule

// File: rtl/rf_read_port.sv
// Module: one combinational read port with write-through forwarding.
// Assumes full_view already holds the active level's low bank below the shared registers.
module rf_read_port #(
    parameter int DATA_W   = 32,
    parameter int NUM_REGS = 16,
    localparam int ADDR_W  = $clog2(NUM_REGS)
) (
    input  logic [ADDR_W-1:0]                 addr,
    input  logic [NUM_REGS-1:0][DATA_W-1:0]   full_view,
    input  logic                              wr_en,
    input  logic [ADDR_W-1:0]                 wr_addr,
    input  logic [DATA_W-1:0]                 wr_data,
    output logic [DATA_W-1:0]                 data
);
    // Purpose: forward a same-cycle write, else return the stored word.
    always_comb begin
        if (wr_en && (wr_addr == addr))
            data = wr_data;
        else
            data = full_view[addr];
    end
endmodule

// File: rtl/shadow_regfile.sv
// Module: top of the priority-banked working register file.
// Registers the priority level and splits each write between the banked and the shared store.
// Two read ports see the low bank of the registered level.
// Assumes the low NUM_BANKED indices are the banked ones.
module shadow_regfile #(
    parameter int DATA_W     = shadow_rf_pkg::RF_DATA_W,
    parameter int NUM_REGS   = shadow_rf_pkg::RF_NUM_REGS,
    parameter int NUM_BANKED = shadow_rf_pkg::RF_NUM_BANKED,
    parameter int NUM_LEVELS = shadow_rf_pkg::RF_NUM_LEVELS,
    localparam int ADDR_W     = $clog2(NUM_REGS),
    localparam int LVL_W      = $clog2(NUM_LEVELS),
    localparam int NUM_SHARED = NUM_REGS - NUM_BANKED,
    localparam int BIDX_W     = $clog2(NUM_BANKED),
    localparam int SIDX_W     = $clog2(NUM_SHARED),
    localparam int NUM_RD     = shadow_rf_pkg::RF_NUM_RD
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [LVL_W-1:0]   level,
    input  logic [ADDR_W-1:0]  rd0_addr,
    output logic [DATA_W-1:0]  rd0_data,
    input  logic [ADDR_W-1:0]  rd1_addr,
    output logic [DATA_W-1:0]  rd1_data,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [DATA_W-1:0]  wr_data
);
    logic [LVL_W-1:0]                   level_q;
    logic                               wr_banked;
    logic [BIDX_W-1:0]                  wr_bidx;
    logic [SIDX_W-1:0]                  wr_sidx;
    logic [NUM_BANKED-1:0][DATA_W-1:0]  low_view;
    logic [NUM_SHARED-1:0][DATA_W-1:0]  high_view;
    logic [NUM_REGS-1:0][DATA_W-1:0]    full_view;
    logic [NUM_RD-1:0][ADDR_W-1:0]      rd_addr_arr;
    logic [NUM_RD-1:0][DATA_W-1:0]      rd_data_arr;

    // Purpose: capture the active level so that a change applies one edge later.
    always_ff @(posedge clk) begin
        if (!rst_n)
            level_q <= '0;
        else
            level_q <= level;
    end

    // Purpose: route the write to the banked or the shared store.
    always_comb begin
        wr_banked = (wr_addr < ADDR_W'(NUM_BANKED));
        wr_bidx   = wr_addr[BIDX_W-1:0];
        wr_sidx   = SIDX_W'(wr_addr - ADDR_W'(NUM_BANKED));
    end

    shadow_bank_store #(
        .DATA_W(DATA_W), .NUM_BANKED(NUM_BANKED), .NUM_LEVELS(NUM_LEVELS)
    ) u_banks (
        .clk(clk), .rst_n(rst_n), .lvl(level_q),
        .we(wr_en && wr_banked), .waddr(wr_bidx), .wdata(wr_data),
        .view(low_view)
    );

    shared_reg_store #(
        .DATA_W(DATA_W), .NUM_SHARED(NUM_SHARED)
    ) u_shared (
        .clk(clk), .rst_n(rst_n),
        .we(wr_en && !wr_banked), .waddr(wr_sidx), .wdata(wr_data),
        .view(high_view)
    );

    assign full_view      = {high_view, low_view};
    assign rd_addr_arr[0] = rd0_addr;
    assign rd_addr_arr[1] = rd1_addr;
    assign rd0_data       = rd_data_arr[0];
    assign rd1_data       = rd_data_arr[1];

    for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
        rf_read_port #(
            .DATA_W(DATA_W), .NUM_REGS(NUM_REGS)
        ) u_port (
            .addr(rd_addr_arr[p]), .full_view(full_view),
            .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
            .data(rd_data_arr[p])
        );
    end
endmodule

// File: rtl/shadow_regfile_checker.sv
// Module: assertion checker bound to shadow_regfile. It observes ports only.
// Assumes the shared registers are the upper half of the index space.
module shadow_regfile_checker #(
    parameter int DATA_W     = 32,
    parameter int NUM_REGS   = 16,
    parameter int NUM_BANKED = 8,
    localparam int ADDR_W    = $clog2(NUM_REGS)
) (
    input logic               clk,
    input logic               rst_n,
    input logic [ADDR_W-1:0]  rd0_addr,
    input logic [DATA_W-1:0]  rd0_data,
    input logic [ADDR_W-1:0]  rd1_addr,
    input logic [DATA_W-1:0]  rd1_data,
    input logic               wr_en,
    input logic [ADDR_W-1:0]  wr_addr,
    input logic [DATA_W-1:0]  wr_data
);
    // R6: a same-cycle write is forwarded to port 0.
    p_bypass_rd0_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == rd0_addr) |-> (rd0_data == wr_data));

    // R6: a same-cycle write is forwarded to port 1.
    p_bypass_rd1_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == rd1_addr) |-> (rd1_data == wr_data));

    // R2: both ports agree when they read the same register.
    p_port_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd0_addr == rd1_addr) |-> (rd0_data == rd1_data));

    // R1: the first cycle after reset reads zero when no write is forwarded.
    p_reset_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!rst_n) && !wr_en) |-> (rd0_data == '0 && rd1_data == '0));

    // R3: a shared register keeps its written value in the next cycle, whatever the level.
    p_shared_persist_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(wr_en) && $past(wr_addr) >= ADDR_W'(NUM_BANKED) && rd0_addr == $past(wr_addr)
         && !(wr_en && wr_addr == rd0_addr))
        |-> (rd0_data == $past(wr_data)));
endmodule

bind shadow_regfile shadow_regfile_checker #(
    .DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .NUM_BANKED(NUM_BANKED)
) u_checker (
    .clk(clk), .rst_n(rst_n),
    .rd0_addr(rd0_addr), .rd0_data(rd0_data),
    .rd1_addr(rd1_addr), .rd1_data(rd1_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
);

// File: tb/tb_shadow_regfile.sv
module tb_shadow_regfile;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  level = '0;
    logic [3:0]  rd0_addr = '0, rd1_addr = '0, wr_addr = '0;
    logic [31:0] rd0_data, rd1_data, wr_data = '0;
    logic        wr_en = 1'b0;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    // Bench model, derived from the requirements
    logic [31:0] low_m [8][8];
    logic [31:0] up_m  [8];
    int          act = 0;

    shadow_regfile dut (
        .clk(clk), .rst_n(rst_n), .level(level),
        .rd0_addr(rd0_addr), .rd0_data(rd0_data),
        .rd1_addr(rd1_addr), .rd1_data(rd1_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    always #5 clk = ~clk;

    function automatic logic [31:0] pat(int l, int r);
        return 32'hC3A5_0000 ^ (32'(l) << 20) ^ (32'(r) * 32'h0001_0101) ^ 32'(l * 7 + r);
    endfunction

    function automatic logic [31:0] expect_rd(int a);
        if (wr_en && int'(wr_addr) == a) return wr_data;
        if (a < 8) return low_m[act][a];
        return up_m[a - 8];
    endfunction

    task automatic clear_model();
        for (int l = 0; l < 8; l++)
            for (int r = 0; r < 8; r++) low_m[l][r] = '0;
        for (int r = 0; r < 8; r++) up_m[r] = '0;
        act = 0;
    endtask

    task automatic check(string req, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h (t=%0t)", req, got, exp, $time);
        end
    endtask

    // Set the read addresses and check both ports mid-cycle.
    task automatic read2(string req, int a0, int a1);
        rd0_addr = 4'(a0);
        rd1_addr = 4'(a1);
        #1;
        check(req, rd0_data, expect_rd(a0));
        check(req, rd1_data, expect_rd(a1));
    endtask

    // Advance one clock edge, update the model, and return at the following negedge.
    task automatic tick();
        @(posedge clk);
        if (rst_n == 1'b0) clear_model();
        else begin
            if (wr_en) begin
                if (wr_addr < 8) low_m[act][wr_addr] = wr_data;
                else up_m[wr_addr - 8] = wr_data;
            end
            act = int'(level);
        end
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic write_reg(int a, logic [31:0] d);
        wr_en = 1'b1;
        wr_addr = 4'(a);
        wr_data = d;
        tick();
    endtask

    task automatic go_level(int l);
        level = 3'(l);
        tick();
    endtask

    initial begin
        clear_model();
        @(negedge clk);
        tick();
        tick();
        rst_n = 1'b1;
        tick();
        // R1: every register reads zero at level 0 and at level 7 after reset
        for (int r = 0; r < 16; r++) read2("R1 reset lvl0", r, 15 - r);
        go_level(7);
        for (int r = 0; r < 8; r++) read2("R1 reset lvl7", r, r);

        // R4 and R3: fill every bank. The upper registers end with level 7's values.
        for (int l = 0; l < 8; l++) begin
            go_level(l);
            for (int r = 0; r < 16; r++) write_reg(r, pat(l, r));
        end
        // R8, R4, R3, R2: sweep every register at every level
        for (int l = 7; l >= 0; l--) begin
            go_level(l);
            for (int r = 0; r < 16; r++) begin
                read2("R4 R8 bank sweep", r, (r + 3) % 16);
                check("R3 shared view", (r >= 8) ? rd0_data : up_m[r % 8], up_m[r % 8]);
            end
        end

        // R7: with wr_en low, nothing changes at the edge
        go_level(4);
        wr_en = 1'b0; wr_addr = 4'd2; wr_data = 32'hDEAD_BEEF;
        tick();
        read2("R7 no write without enable", 2, 2);
        check("R7 value kept", rd0_data, pat(4, 2));

        // R6: a write is forwarded in the same cycle, on both ports
        wr_en = 1'b1; wr_addr = 4'd5; wr_data = 32'h1234_5678;
        read2("R6 bypass", 5, 5);
        check("R6 port0 forwarded", rd0_data, 32'h1234_5678);
        read2("R6 other reg unaffected", 6, 9);
        tick();
        read2("R6 write landed", 5, 5);

        // R5: level changes in the same cycle as a write. The write and reads still use level 4.
        level = 3'd6;
        wr_en = 1'b1; wr_addr = 4'd1; wr_data = 32'hAAAA_0001;
        read2("R5 old level in change cycle", 3, 1);
        check("R5 old bank read", rd0_data, pat(4, 3));
        tick();
        read2("R5 new level after edge", 1, 3);
        check("R5 level 6 bank", rd0_data, pat(6, 1));
        go_level(4);
        read2("R5 R8 write landed in old bank", 1, 1);
        check("R5 old bank holds write", rd0_data, 32'hAAAA_0001);

        // R3: a shared write at level 2 is seen at level 0
        go_level(2);
        write_reg(12, 32'h0BAD_F00D);
        go_level(0);
        read2("R3 shared across levels", 12, 12);
        check("R3 shared value", rd0_data, 32'h0BAD_F00D);

        // R1: a second reset clears all the banks again
        rst_n = 1'b0;
        tick();
        rst_n = 1'b1;
        level = 3'd5;
        read2("R1 reset level 0 active", 4, 11);
        tick();
        for (int r = 0; r < 16; r++) read2("R1 second reset", r, r);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule